// File: doc/BRIEF.md
# Byte-Coded Stack Machine Core

This block runs a compact byte-coded program directly in hardware. It reads one opcode byte at a time from a code memory at the address held in its code pointer, maps the byte to a handler, and executes that handler against an evaluation stack kept in word-wide data memory. The stack grows downward. Local variables live in an area that starts at an environment base address, and each local is addressed by a byte offset scaled to a word.

The core has four working operations: add the two top words, increment the top word, push a 16-bit immediate, and store the top word to a local. A halt opcode ends a program cleanly. Any unassigned opcode raises a sticky illegal flag and freezes the core. On reset the code pointer, stack pointer and environment base load from configuration inputs. The core then waits for a start pulse. Both memory ports are combinational reads: the read data must be valid in the same cycle as the address. Data memory addresses are byte addresses, and every access the core makes is to an even address.

Top module: `bytecode_stack_core`

## Requirements
- R1: While reset is low, and afterwards until `start` is sampled high, the core writes nothing to data memory, both flags read 0, and `code_addr` holds `cfg_cp`.
- R2: Every code byte is read at `code_addr`, and the code pointer advances by exactly one after each byte it consumes. After a program stops, `code_addr` equals `cfg_cp` plus the number of bytes consumed.
- R3: ADD (opcode 0x01) pops the top word and adds it to the word below, modulo 2^16, leaving the sum as the new top. No overflow indication is produced. It takes 4 cycles including fetch and decode.
- R4: INC (opcode 0x02) adds one, modulo 2^16, to the top word in place and leaves the stack pointer unchanged. It takes 3 cycles.
- R5: PUSH (opcode 0x03) reads two further code bytes, the high byte first. It writes the assembled word at stack pointer minus 2, which becomes the new stack pointer. It takes 5 cycles.
- R6: STORE-LOCAL (opcode 0x04) reads one offset byte k, pops the top word and writes it to byte address `cfg_env + 2*k`. It takes 5 cycles.
- R7: Any opcode from 0x05 to 0xFF sets `illegal` and `halted` 2 cycles after its fetch begins. Both stay set until reset, and the core makes no further data write and no further code pointer change.
- R8: HALT (opcode 0x00) sets `halted` 2 cycles after its fetch begins, while `illegal` stays 0. It then makes no further data write and no further code pointer change.
- R9: Data memory writes always go to even byte addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads the configuration |
| start | input | 1 | Begins the fetch loop when sampled high in the idle state |
| cfg_cp | input | AW | Code pointer loaded at reset |
| cfg_sp | input | AW | Stack pointer loaded at reset (even) |
| cfg_env | input | AW | Environment base loaded at reset (even) |
| code_addr | output | AW | Code memory byte address (the code pointer) |
| code_rdata | input | 8 | Code byte at `code_addr`, same cycle |
| dm_addr | output | AW | Data memory byte address |
| dm_rdata | input | 16 | Data word at `dm_addr`, same cycle |
| dm_wdata | output | 16 | Data word to write |
| dm_we | output | 1 | Write strobe for `dm_wdata` at `dm_addr` |
| halted | output | 1 | Core has stopped (halt or illegal opcode) |
| illegal | output | 1 | Sticky flag: an unassigned opcode was decoded |

## Verification
The assertions check on every cycle that writes are word aligned, that the illegal flag is sticky and implies a stop, and that a stopped core neither writes nor moves its code pointer. The stack arithmetic, the byte order of immediates, the scaling of local offsets, the wrap at 2^16 and the per-opcode cycle counts are not visible to such properties. Only the bench's sweeps show them, by comparing memory contents, the final code address and measured run lengths against values computed from each program.

// File: rtl/bytecode_stack_core.sv
module bytecode_stack_core #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_cp,
  input  logic [AW-1:0] cfg_sp,
  input  logic [AW-1:0] cfg_env,
  output logic [AW-1:0] code_addr,
  input  logic [7:0]    code_rdata,
  output logic [AW-1:0] dm_addr,
  input  logic [15:0]   dm_rdata,
  output logic [15:0]   dm_wdata,
  output logic          dm_we,
  output logic          halted,
  output logic          illegal
);
  localparam logic [7:0] OP_HALT = 8'h00;
  localparam logic [7:0] OP_ADD  = 8'h01;
  localparam logic [7:0] OP_INC  = 8'h02;
  localparam logic [7:0] OP_PUSH = 8'h03;
  localparam logic [7:0] OP_STL  = 8'h04;
  localparam logic [AW-1:0] TWO  = AW'(2);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_ADD1, S_ADD2, S_INC,
    S_PHI, S_PLO, S_PWR, S_SOFF, S_SPOP, S_SWR, S_STOP
  } st_t;

  st_t           st;
  logic [AW-1:0] cp, sp, env;
  logic [7:0]    op, off;
  logic [15:0]   tmp;
  logic          halt_q, ill_q;

  function automatic st_t dispatch(input logic [7:0] code);
    case (code)
      OP_ADD:  dispatch = S_ADD1;
      OP_INC:  dispatch = S_INC;
      OP_PUSH: dispatch = S_PHI;
      OP_STL:  dispatch = S_SOFF;
      default: dispatch = S_STOP;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cp     <= cfg_cp;
      sp     <= cfg_sp;
      env    <= cfg_env;
      op     <= '0;
      off    <= '0;
      tmp    <= '0;
      halt_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (start) st <= S_FETCH;
        S_FETCH: begin op <= code_rdata; cp <= cp + 1'b1; st <= S_DEC; end
        S_DEC: begin
          st <= dispatch(op);
          if (dispatch(op) == S_STOP) begin
            halt_q <= 1'b1;
            ill_q  <= (op != OP_HALT);
          end
        end
        S_ADD1:  begin tmp <= dm_rdata; sp <= sp + TWO; st <= S_ADD2; end
        S_ADD2:  st <= S_FETCH;
        S_INC:   st <= S_FETCH;
        S_PHI:   begin tmp[15:8] <= code_rdata; cp <= cp + 1'b1; st <= S_PLO; end
        S_PLO:   begin tmp[7:0] <= code_rdata; cp <= cp + 1'b1; st <= S_PWR; end
        S_PWR:   begin sp <= sp - TWO; st <= S_FETCH; end
        S_SOFF:  begin off <= code_rdata; cp <= cp + 1'b1; st <= S_SPOP; end
        S_SPOP:  begin tmp <= dm_rdata; sp <= sp + TWO; st <= S_SWR; end
        S_SWR:   st <= S_FETCH;
        default: st <= S_STOP;
      endcase
    end
  end

  assign code_addr = cp;
  assign halted    = halt_q;
  assign illegal   = ill_q;
  assign dm_we     = (st == S_ADD2) || (st == S_INC) || (st == S_PWR) || (st == S_SWR);

  always_comb begin
    case (st)
      S_PWR:   dm_addr = sp - TWO;
      S_SWR:   dm_addr = env + AW'({off, 1'b0});
      default: dm_addr = sp;
    endcase
    case (st)
      S_ADD2:  dm_wdata = dm_rdata + tmp;
      S_INC:   dm_wdata = dm_rdata + 16'd1;
      default: dm_wdata = tmp;
    endcase
  end
endmodule

module bytecode_stack_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] code_addr,
  input logic [AW-1:0] dm_addr,
  input logic          dm_we,
  input logic          halted,
  input logic          illegal
);
  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) dm_we |-> !dm_addr[0]); // R9
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> illegal); // R7
  AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted); // R7
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !dm_we); // R8
  AST_HALT_CP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(code_addr)); // R8
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R8
endmodule

bind bytecode_stack_core bytecode_stack_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_addr(code_addr), .dm_addr(dm_addr),
  .dm_we(dm_we), .halted(halted), .illegal(illegal)
);

// File: tb/bytecode_stack_core_test.sv
`timescale 1ns/1ps
module bytecode_stack_core_test;
  localparam int AW = 16;
  localparam logic [15:0] CP0  = 16'h0010;
  localparam logic [15:0] SP0  = 16'h0080;
  localparam logic [15:0] ENV0 = 16'h0020;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] code_addr, dm_addr;
  logic [7:0]    code_rdata;
  logic [15:0]   dm_rdata, dm_wdata;
  logic          dm_we, halted, illegal;

  logic [7:0]  cmem [256];
  logic [15:0] dmem [128];
  int          wr_cnt = 0;
  int          checks = 0;
  int          fails  = 0;
  int          wp;
  int          cyc;

  always #5 clk = ~clk;

  assign code_rdata = cmem[code_addr[7:0]];
  assign dm_rdata   = dmem[dm_addr[7:1]];

  always @(posedge clk) if (dm_we) begin
    dmem[dm_addr[7:1]] <= dm_wdata;
    wr_cnt = wr_cnt + 1;
  end

  bytecode_stack_core #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_cp(CP0), .cfg_sp(SP0), .cfg_env(ENV0),
    .code_addr(code_addr), .code_rdata(code_rdata),
    .dm_addr(dm_addr), .dm_rdata(dm_rdata), .dm_wdata(dm_wdata), .dm_we(dm_we),
    .halted(halted), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) cmem[i] = 8'h00;
    for (int i = 0; i < 128; i++) dmem[i] = 16'h0000;
    wp = CP0;
  endtask

  task automatic put(input logic [7:0] b);
    cmem[wp] = b;
    wp++;
  endtask

  task automatic run();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    wr_cnt = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!halted && cyc < 300) begin
      @(negedge clk);
      if (!halted) cyc++;
    end
    if (cyc >= 300) chk(1'b0, "R7 watchdog run", cyc, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] a, b, v, s;
    clear_prog();
    // R1: reset and idle state
    @(negedge clk); @(negedge clk);
    chk(!halted && !illegal && !dm_we, "R1 flags in reset", {halted, illegal, dm_we}, 0);
    chk(code_addr == CP0, "R1 cp in reset", code_addr, CP0);
    rst_n = 1'b1;
    wr_cnt = 0;
    repeat (5) @(negedge clk);
    chk(wr_cnt == 0 && !halted && code_addr == CP0, "R1 idle before start", code_addr, CP0);

    // R8: halt only
    clear_prog(); put(8'h00); run();
    chk(halted && !illegal, "R8 halt flags", {halted, illegal}, 2);
    chk(cyc == 2, "R8 halt cycles", cyc, 2);
    repeat (4) @(negedge clk);
    chk(code_addr == CP0 + 1 && wr_cnt == 0, "R8 frozen after halt", code_addr, CP0 + 1);

    // R5: push byte order and address
    clear_prog(); put(8'h03); put(8'h12); put(8'h34); put(8'h00); run();
    chk(dmem[(SP0 - 2) >> 1] == 16'h1234, "R5 push word", dmem[(SP0 - 2) >> 1], 16'h1234);
    chk(cyc == 7, "R5 push cycles", cyc, 7);
    chk(code_addr == CP0 + 4, "R2 cp after push", code_addr, CP0 + 4);

    // R3: add sweep with wrap
    for (int i = 0; i < 16; i++) begin
      a = 16'(i * 16'h1357 + 16'hF000);
      b = 16'(i * 16'h0F0F + 16'h0FFF);
      if (i == 0) begin a = 16'hFFFF; b = 16'h0001; end
      s = a + b;
      clear_prog();
      put(8'h03); put(a[15:8]); put(a[7:0]);
      put(8'h03); put(b[15:8]); put(b[7:0]);
      put(8'h01); put(8'h04); put(8'h00); put(8'h00);
      run();
      chk(dmem[ENV0 >> 1] == s, "R3 add sum stored", dmem[ENV0 >> 1], s);
      chk(dmem[(SP0 - 2) >> 1] == s, "R3 add top of stack", dmem[(SP0 - 2) >> 1], s);
      chk(cyc == 21, "R3 add program cycles", cyc, 21);
      chk(wr_cnt == 4 && !illegal, "R3 write count", wr_cnt, 4);
      chk(code_addr == CP0 + 10, "R2 cp after add program", code_addr, CP0 + 10);
    end

    // R4 and R6: inc sweep with offset sweep
    for (int k = 0; k < 16; k++) begin
      v = (k < 2) ? 16'(16'hFFFE + k) : 16'(k * 16'h0911);
      s = v + 16'd2;
      clear_prog();
      put(8'h03); put(v[15:8]); put(v[7:0]);
      put(8'h02); put(8'h02);
      put(8'h04); put(8'(k)); put(8'h00);
      run();
      chk(dmem[(ENV0 + 2 * k) >> 1] == s, "R6 store at scaled offset", dmem[(ENV0 + 2 * k) >> 1], s);
      chk(dmem[(SP0 - 2) >> 1] == s, "R4 inc in place", dmem[(SP0 - 2) >> 1], s);
      chk(cyc == 18, "R4 inc program cycles", cyc, 18);
      chk(code_addr == CP0 + 8, "R2 cp after inc program", code_addr, CP0 + 8);
    end

    // R6: store pops so a second store takes the next word
    clear_prog();
    put(8'h03); put(8'hAA); put(8'h55);
    put(8'h03); put(8'h00); put(8'h07);
    put(8'h04); put(8'h01); put(8'h04); put(8'h02); put(8'h00);
    run();
    chk(dmem[(ENV0 + 2) >> 1] == 16'h0007, "R6 first store", dmem[(ENV0 + 2) >> 1], 16'h0007);
    chk(dmem[(ENV0 + 4) >> 1] == 16'hAA55, "R6 second store pops", dmem[(ENV0 + 4) >> 1], 16'hAA55);

    // R7: every unassigned opcode
    for (int o = 5; o < 256; o++) begin
      clear_prog(); put(8'(o)); put(8'h01); run();
      repeat (3) @(negedge clk);
      chk(halted && illegal, "R7 illegal flags", {halted, illegal}, 3);
      chk(cyc == 2 && wr_cnt == 0, "R7 illegal stop", cyc, 2);
      chk(code_addr == CP0 + 1, "R7 cp frozen", code_addr, CP0 + 1);
    end

    // R7: illegal after valid work, start ignored while stopped
    clear_prog(); put(8'h03); put(8'h00); put(8'h01); put(8'hFF); run();
    start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;
    chk(illegal && code_addr == CP0 + 4 && wr_cnt == 1, "R7 sticky after start", code_addr, CP0 + 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule